// File: doc/BRIEF.md
# Shifted Window Base Register with Byte Window Translator

This block lets an 8-bit sound coprocessor see a 32 KB slice of the main processor's 24-bit address space. The slice's base is held in a register that neither processor can write in one go. Each processor has its own one-bit load strobe. A load pushes bit 0 of the written data in at address bit 23 and moves the rest of the base down by one place. Every base bit below the window size always reads as zero, so nine loads define a complete base.

While the coprocessor touches its window, the block forms the full main-bus byte address as base plus the 15-bit window offset. It drives a single-byte request onto a main-bus request port in the same cycle and hands the main-bus read byte straight back. Main-bus arbitration and wait states belong to the surrounding logic.

Top module: `bank_window_unit`

## Requirements
- R1: A synchronous, active-high reset clears the base to 0x000000; the cleared value is visible in the cycle after the reset edge.
- R2: A main-CPU load (`host_bit_we` high at a rising edge) sets the new base to the old base shifted right by one bit, with `host_bit_data[0]` entering at bit 23. The new value is visible after that edge.
- R3: Base bits 14 down to 0 read as zero at all times. A bit that is shifted below bit 15 is discarded.
- R4: A main-CPU load uses only `host_bit_data[0]`. Data bits 15 to 1 have no effect on the base.
- R5: A coprocessor load (`snd_bit_we`) shifts the base in the same way, using only `snd_bit_data[0]`. Bits 7 to 1 have no effect.
- R6: When both load strobes are high at the same edge, only the main-CPU bit is shifted in. The coprocessor bit is dropped, so the base moves by exactly one place.
- R7: Nine loads with bits b0 first through b8 last leave the base equal to {b8..b0, 15'b0}. A tenth load discards b0.
- R8: While `win_req` is high, `mbus_req` is high and `mbus_addr` equals base + `win_off` in the same cycle. `mbus_req` is low whenever `win_req` is low.
- R9: A window access is a single byte. `mbus_we` follows `win_we`, `mbus_wdata` follows `win_wdata`, and `win_rdata` returns `mbus_rdata`, all combinationally.
- R10: In a cycle with no load strobe, the base keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bit_we | input | 1 | Main-CPU load strobe for the base register |
| host_bit_data | input | 16 | Main-CPU write data; only bit 0 is used |
| snd_bit_we | input | 1 | Coprocessor load strobe for the base register |
| snd_bit_data | input | 8 | Coprocessor write data; only bit 0 is used |
| win_req | input | 1 | Coprocessor access into the window |
| win_we | input | 1 | Access is a write (1) or a read (0) |
| win_off | input | 15 | Byte offset inside the window |
| win_wdata | input | 8 | Byte to write |
| win_rdata | output | 8 | Byte read back from the main bus |
| mbus_req | output | 1 | Main-bus byte request |
| mbus_we | output | 1 | Main-bus write enable |
| mbus_addr | output | 24 | Main-bus byte address |
| mbus_wdata | output | 8 | Main-bus write byte |
| mbus_rdata | input | 8 | Main-bus read byte |
| win_base | output | 24 | Current window base address |

## Verification
The bench loads data words whose upper bits are all ones but whose bit 0 is zero. A design that took any bit other than bit 0 would move a one into the base. It fires both strobes together with opposite bits: a design that gave the coprocessor priority would show the wrong top bit, and one that shifted twice would move the base by two places. A run of nine loads, and then a tenth, exposes a register that is too short or one that keeps a bit below bit 15, because the tenth load would then leave a nonzero low address bit. Window accesses at offsets 0 and 0x7FFF check for an address built from the wrong bits or carried across the base.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;

    localparam int MAIN_ADDR_W = 24;
    localparam int WIN_OFF_W   = 15;
    localparam int BYTE_W      = 8;
    localparam int HOST_DATA_W = 16;
    localparam int SND_DATA_W  = 8;

    // One shift-in request after arbitration between the two writers.
    typedef struct packed {
        logic valid;
        logic bit_in;
    } shift_req_t;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_HOST = 2'd1,
        LOAD_SND  = 2'd2
    } load_src_e;

    // Inserts one bit at the top of the kept field and drops the lowest.
    function automatic logic [MAIN_ADDR_W-WIN_OFF_W-1:0] push_top(
        input logic [MAIN_ADDR_W-WIN_OFF_W-1:0] cur,
        input logic                             b
    );
        logic [MAIN_ADDR_W-WIN_OFF_W-1:0] nxt;
        nxt = cur >> 1;
        nxt[MAIN_ADDR_W-WIN_OFF_W-1] = b;
        return nxt;
    endfunction

endpackage

// File: rtl/bank_window_load_arb.sv
module bank_window_load_arb
    import bank_window_pkg::*;
#(
    parameter int HOST_DW = HOST_DATA_W,
    parameter int SND_DW  = SND_DATA_W
) (
    input  logic               host_we,
    input  logic [HOST_DW-1:0] host_data,
    input  logic               snd_we,
    input  logic [SND_DW-1:0]  snd_data,
    output shift_req_t         req
);
    load_src_e src;

    // Upper data bits play no part in a load.
    logic unused_upper;
    assign unused_upper = ^{host_data[HOST_DW-1:1], snd_data[SND_DW-1:1]};

    always_comb begin
        if (host_we)     src = LOAD_HOST;
        else if (snd_we) src = LOAD_SND;
        else             src = LOAD_NONE;
    end

    always_comb begin
        unique case (src)
            LOAD_HOST: req = '{valid: 1'b1, bit_in: host_data[0]};
            LOAD_SND:  req = '{valid: 1'b1, bit_in: snd_data[0]};
            default:   req = '{valid: 1'b0, bit_in: 1'b0};
        endcase
    end
endmodule

// File: rtl/bank_window_base_reg.sv
module bank_window_base_reg
    import bank_window_pkg::*;
#(
    parameter int ADDR_W = MAIN_ADDR_W,
    parameter int OFF_W  = WIN_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_req_t        ld,
    output logic [ADDR_W-1:0] base
);
    localparam int KEEP_W = ADDR_W - OFF_W;

    logic [KEEP_W-1:0] kept_q;
    logic [KEEP_W-1:0] kept_d;

    generate
        if (KEEP_W == 1) begin : g_single
            assign kept_d = ld.valid ? ld.bit_in : kept_q;
        end else begin : g_shift
            always_comb begin
                kept_d = kept_q;
                if (ld.valid) begin
                    kept_d = {ld.bit_in, kept_q[KEEP_W-1:1]};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) kept_q <= '0;
        else     kept_q <= kept_d;
    end

    assign base = {kept_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate
    import bank_window_pkg::*;
#(
    parameter int ADDR_W = MAIN_ADDR_W,
    parameter int OFF_W  = WIN_OFF_W,
    parameter int DW     = BYTE_W
) (
    input  logic              [ADDR_W-1:0] base,
    input  logic                           win_req,
    input  logic                           win_we,
    input  logic              [OFF_W-1:0]  win_off,
    input  logic              [DW-1:0]     win_wdata,
    output logic              [DW-1:0]     win_rdata,
    output logic                           mbus_req,
    output logic                           mbus_we,
    output logic              [ADDR_W-1:0] mbus_addr,
    output logic              [DW-1:0]     mbus_wdata,
    input  logic              [DW-1:0]     mbus_rdata
);
    assign mbus_req   = win_req;
    assign mbus_we    = win_req & win_we;
    assign mbus_addr  = base + ADDR_W'(win_off);
    assign mbus_wdata = win_wdata;
    assign win_rdata  = mbus_rdata;
endmodule

// File: rtl/bank_window_unit.sv
module bank_window_unit
    import bank_window_pkg::*;
#(
    parameter int ADDR_W  = MAIN_ADDR_W,
    parameter int OFF_W   = WIN_OFF_W,
    parameter int DW      = BYTE_W,
    parameter int HOST_DW = HOST_DATA_W,
    parameter int SND_DW  = SND_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_bit_we,
    input  logic [HOST_DW-1:0] host_bit_data,
    input  logic               snd_bit_we,
    input  logic [SND_DW-1:0]  snd_bit_data,
    input  logic               win_req,
    input  logic               win_we,
    input  logic [OFF_W-1:0]   win_off,
    input  logic [DW-1:0]      win_wdata,
    output logic [DW-1:0]      win_rdata,
    output logic               mbus_req,
    output logic               mbus_we,
    output logic [ADDR_W-1:0]  mbus_addr,
    output logic [DW-1:0]      mbus_wdata,
    input  logic [DW-1:0]      mbus_rdata,
    output logic [ADDR_W-1:0]  win_base
);
    shift_req_t ld;

    bank_window_load_arb #(.HOST_DW(HOST_DW), .SND_DW(SND_DW)) u_arb (
        .host_we   (host_bit_we),
        .host_data (host_bit_data),
        .snd_we    (snd_bit_we),
        .snd_data  (snd_bit_data),
        .req       (ld)
    );

    bank_window_base_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_base (
        .clk  (clk),
        .rst  (rst),
        .ld   (ld),
        .base (win_base)
    );

    bank_window_xlate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DW(DW)) u_xlate (
        .base       (win_base),
        .win_req    (win_req),
        .win_we     (win_we),
        .win_off    (win_off),
        .win_wdata  (win_wdata),
        .win_rdata  (win_rdata),
        .mbus_req   (mbus_req),
        .mbus_we    (mbus_we),
        .mbus_addr  (mbus_addr),
        .mbus_wdata (mbus_wdata),
        .mbus_rdata (mbus_rdata)
    );
endmodule

// File: rtl/bank_window_unit_chk.sv
module bank_window_unit_chk #(
    parameter int ADDR_W  = 24,
    parameter int OFF_W   = 15,
    parameter int DW      = 8,
    parameter int HOST_DW = 16,
    parameter int SND_DW  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               host_bit_we,
    input logic [HOST_DW-1:0] host_bit_data,
    input logic               snd_bit_we,
    input logic [SND_DW-1:0]  snd_bit_data,
    input logic               win_req,
    input logic               win_we,
    input logic [OFF_W-1:0]   win_off,
    input logic [DW-1:0]      win_wdata,
    input logic [DW-1:0]      win_rdata,
    input logic               mbus_req,
    input logic               mbus_we,
    input logic [ADDR_W-1:0]  mbus_addr,
    input logic [DW-1:0]      mbus_wdata,
    input logic [DW-1:0]      mbus_rdata,
    input logic [ADDR_W-1:0]  win_base
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (win_base == '0));

    // R2 and R4: only data bit 0 of a main-CPU load enters at the top.
    p_host_shift_r2: assert property (@(posedge clk) disable iff (rst)
        host_bit_we |=> (win_base[ADDR_W-1] == $past(host_bit_data[0]))
                     && (win_base[ADDR_W-2:OFF_W] == $past(win_base[ADDR_W-1:OFF_W+1])));

    p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
        win_base[OFF_W-1:0] == '0);

    p_snd_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (snd_bit_we && !host_bit_we) |=> (win_base[ADDR_W-1] == $past(snd_bit_data[0]))
                     && (win_base[ADDR_W-2:OFF_W] == $past(win_base[ADDR_W-1:OFF_W+1])));

    p_host_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (snd_bit_we && host_bit_we) |=> (win_base[ADDR_W-1] == $past(host_bit_data[0])));

    p_addr_sum_r8: assert property (@(posedge clk) disable iff (rst)
        win_req |-> (mbus_req && (mbus_addr == win_base + ADDR_W'(win_off))));

    p_no_req_r8: assert property (@(posedge clk) disable iff (rst)
        !win_req |-> !mbus_req);

    p_pass_r9: assert property (@(posedge clk) disable iff (rst)
        win_req |-> (mbus_we == win_we) && (mbus_wdata == win_wdata)
                    && (win_rdata == mbus_rdata));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!host_bit_we && !snd_bit_we) |=> $stable(win_base));
endmodule

bind bank_window_unit bank_window_unit_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DW(DW), .HOST_DW(HOST_DW), .SND_DW(SND_DW)
) u_chk (
    .clk(clk), .rst(rst),
    .host_bit_we(host_bit_we), .host_bit_data(host_bit_data),
    .snd_bit_we(snd_bit_we), .snd_bit_data(snd_bit_data),
    .win_req(win_req), .win_we(win_we), .win_off(win_off), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .mbus_req(mbus_req), .mbus_we(mbus_we),
    .mbus_addr(mbus_addr), .mbus_wdata(mbus_wdata), .mbus_rdata(mbus_rdata),
    .win_base(win_base)
);

// File: tb/sim_bank_window_unit.sv
`timescale 1ns/1ps
module sim_bank_window_unit;
    localparam int CLK_PERIOD = 10;

    typedef enum int { K_BASE, K_ADDR, K_REQ, K_WE, K_WDATA, K_RDATA } kind_e;
    typedef struct {
        kind_e       kind;
        logic [23:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_bit_we;
    logic [15:0] host_bit_data;
    logic        snd_bit_we;
    logic [7:0]  snd_bit_data;
    logic        win_req;
    logic        win_we;
    logic [14:0] win_off;
    logic [7:0]  win_wdata;
    logic [7:0]  win_rdata;
    logic        mbus_req;
    logic        mbus_we;
    logic [23:0] mbus_addr;
    logic [7:0]  mbus_wdata;
    logic [7:0]  mbus_rdata;
    logic [23:0] win_base;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [8:0] model_hi = '0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_window_unit u0 (
        .clk(clk), .rst(rst),
        .host_bit_we(host_bit_we), .host_bit_data(host_bit_data),
        .snd_bit_we(snd_bit_we), .snd_bit_data(snd_bit_data),
        .win_req(win_req), .win_we(win_we), .win_off(win_off), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .mbus_req(mbus_req), .mbus_we(mbus_we),
        .mbus_addr(mbus_addr), .mbus_wdata(mbus_wdata), .mbus_rdata(mbus_rdata),
        .win_base(win_base)
    );

    function automatic logic [23:0] model_base();
        return {model_hi, 15'b0};
    endfunction

    task automatic push(input kind_e k, input logic [23:0] e, input string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    // Monitor: compares every queued expectation away from the clock edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_BASE:  act = win_base;
                K_ADDR:  act = mbus_addr;
                K_REQ:   act = {23'b0, mbus_req};
                K_WE:    act = {23'b0, mbus_we};
                K_WDATA: act = {16'b0, mbus_wdata};
                default: act = {16'b0, win_rdata};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %06h expected %06h", it.tag, act, it.exp);
            end
        end
    end

    // Driver: one load cycle, then queue the expected base.
    task automatic load(input logic h_en, input logic [15:0] hd,
                        input logic s_en, input logic [7:0] sd, input string t);
        @(negedge clk);
        host_bit_we = h_en; host_bit_data = hd;
        snd_bit_we  = s_en; snd_bit_data  = sd;
        @(posedge clk); #1;
        host_bit_we = 1'b0; snd_bit_we = 1'b0;
        if (h_en)      model_hi = {hd[0], model_hi[8:1]};
        else if (s_en) model_hi = {sd[0], model_hi[8:1]};
        push(K_BASE, model_base(), t);
    endtask

    task automatic idle(input int n, input string t);
        repeat (n) @(posedge clk);
        #1;
        push(K_BASE, model_base(), t);
    endtask

    task automatic access(input logic we, input logic [14:0] off,
                          input logic [7:0] wd, input logic [7:0] rd);
        @(posedge clk); #1;
        win_req = 1'b1; win_we = we; win_off = off; win_wdata = wd; mbus_rdata = rd;
        push(K_REQ,   24'd1, "R8 request");
        push(K_ADDR,  model_base() + {9'b0, off}, "R8 address");
        push(K_WE,    {23'b0, we}, "R9 write enable");
        push(K_WDATA, {16'b0, wd}, "R9 write byte");
        push(K_RDATA, {16'b0, rd}, "R9 read byte");
        @(posedge clk); #1;
        win_req = 1'b0; win_we = 1'b0;
        push(K_REQ, 24'd0, "R8 no request");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] pat;
        rst = 1'b1;
        host_bit_we = 0; host_bit_data = '0; snd_bit_we = 0; snd_bit_data = '0;
        win_req = 0; win_we = 0; win_off = '0; win_wdata = '0; mbus_rdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        model_hi = '0;
        push(K_BASE, 24'h000000, "R1 reset value");

        // R4: upper bits set, bit 0 clear, so base stays zero.
        load(1, 16'hFFFE, 0, 8'h00, "R4 host upper bits ignored");
        load(1, 16'h0001, 0, 8'h00, "R2 host shift of a one");
        // R5: coprocessor upper bits set, bit 0 clear.
        load(0, 16'h0000, 1, 8'hFE, "R5 snd upper bits ignored");
        load(0, 16'h0000, 1, 8'h01, "R5 snd shift of a one");
        // R6: both strobes, host bit 1 against snd bit 0, then reversed.
        load(1, 16'h0001, 1, 8'h00, "R6 host wins bit 1");
        load(1, 16'h0000, 1, 8'hFF, "R6 host wins bit 0");
        idle(4, "R10 base holds while idle");

        // R7: nine loads build a full base, lowest bit first.
        pat = 9'h1A5;
        for (int i = 0; i < 9; i++) begin
            load(i[0], {15'b0, pat[i]}, !i[0], {7'b0, pat[i]}, "R7 nine-load sequence");
        end
        push(K_BASE, {9'h1A5, 15'b0}, "R7 full base");
        load(1, 16'h0000, 0, 8'h00, "R3 tenth load drops lowest bit");
        push(K_BASE, {1'b0, 8'hD2, 15'b0}, "R3 low bits stay zero");

        // R8 / R9: window accesses at edges and inside.
        access(1'b0, 15'h0000, 8'h00, 8'h5A);
        access(1'b1, 15'h7FFF, 8'hC3, 8'h00);
        access(1'b1, 15'h1234, 8'h81, 8'h7E);
        for (int i = 0; i < 9; i++) load(1, 16'hFFFF, 0, 8'h00, "R2 fill with ones");
        access(1'b0, 15'h7FFF, 8'h00, 8'hA5);

        // R1: reset in mid-operation.
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        model_hi = '0;
        push(K_BASE, 24'h000000, "R1 reset clears loaded base");
        idle(2, "R10 hold after reset");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule